// File: doc/BRIEF.md
# Synchronized Glitch-Free Clock Stop Gate

This block turns one clock group off and on in response to an asynchronous active-low stop request, without ever producing a shortened pulse. The request is captured in the domain of the clock being gated. The gated output always comes to rest in the low state. When it restarts, its first high phase has full width. A second output carries the input clock ungated, so that loads needing a clock that never stops can take it from the same place.

A parameter picks the clock group. The processor group passes the request through one extra capture flop and then holds the clock on for at least 100 of its own cycles after every restart. The peripheral-bus group reacts one edge sooner and holds the clock on for at least 10 cycles. An active-low power-down input overrides the stop request and parks the gated clock low at once, even if the minimum on-time has not yet run out. A stop request that arrives before the minimum on-time has elapsed is held back until that time is complete.

Top module: `clk_stop_gate`

## Requirements
- R1: While reset is asserted, `gclk_o` is low at all times.
- R2: `fclk_o` follows `clk_i` at all times, whatever the state of reset, `stop_n` and `pwrdn_n`.
- R3: `gclk_o` is low whenever `clk_i` is low. Every high phase of `gclk_o` begins on a rising edge of `clk_i` and lasts until the following falling edge.
- R4: Say `stop_n` falls during a low phase of `clk_i` while the minimum on-time is already met, and call the next rising edges 1, 2, 3 and so on. In the processor group, `gclk_o` still pulses at edges 1 and 2 and is silent from edge 3 on. In the bus group, it pulses at edge 1 only.
- R5: Say `stop_n` and `pwrdn_n` are both high and the clock is parked, counting edges as in R4. This applies when `stop_n` rises and also on release of reset. The first pulse comes at edge 3 in the processor group and at edge 2 in the bus group.
- R6: After each restart, `gclk_o` delivers at least MIN_ON pulses before a stop request takes effect. A stop request that returns to low during this time is held until exactly MIN_ON pulses have been delivered, and the clock then parks.
- R7: A low `pwrdn_n` stops `gclk_o` with the latency of R4, even before the minimum on-time has run out. While `pwrdn_n` is low, `stop_n` has no effect. Raising `pwrdn_n` with `stop_n` high restarts the clock with the latency of R5.
- R8: The group parameter selects MIN_ON = 100 with one pre-capture flop (processor group, encoding 0) or MIN_ON = 10 with none (bus group, encoding 1).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock of the group being gated |
| rst_n | input | 1 | Asynchronous active-low reset; parks the gate |
| stop_n | input | 1 | Asynchronous stop request, low = stop |
| pwrdn_n | input | 1 | Asynchronous power-down override, low = force the gated clock low |
| gclk_o | output | 1 | Gated clock |
| fclk_o | output | 1 | Free-running copy of `clk_i` |

## Verification
The assertions take for granted that `stop_n` and `pwrdn_n`, although asynchronous, stay at each level for at least one full clock period. This lets the checker, which samples on falling edges, see every level that the capture flops see. The latency properties also assume that inputs change away from rising edges. Without that, the edge counting in R4, R5 and R7 would be ambiguous by one cycle. The bench changes every control input shortly after a falling edge and holds it for at least one period, so every stimulus stays within both assumptions.

// File: rtl/csg_pkg.sv
package csg_pkg;

    typedef enum logic {
        GRP_CPU = 1'b0,
        GRP_BUS = 1'b1
    } clk_group_e;

    function automatic int unsigned min_on_cycles(clk_group_e grp);
        return (grp == GRP_CPU) ? 100 : 10;
    endfunction

    function automatic int unsigned pre_sync_stages(clk_group_e grp);
        return (grp == GRP_CPU) ? 1 : 0;
    endfunction

endpackage

// File: rtl/csg_sync.sv
module csg_sync #(
    parameter int unsigned STAGES = 1,
    parameter int unsigned WIDTH  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    generate
        if (STAGES == 0) begin : g_bypass
            assign q = d;
        end else begin : g_pipe
            logic [STAGES-1:0][WIDTH-1:0] pipe_d, pipe_q;

            always_comb begin
                pipe_d[0] = d;
                for (int i = 1; i < int'(STAGES); i++) begin
                    pipe_d[i] = pipe_q[i-1];
                end
            end

            // reset to all-zero: request stop, power-down asserted
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pipe_q <= '0;
                else        pipe_q <= pipe_d;
            end

            assign q = pipe_q[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/csg_ctrl.sv
module csg_ctrl #(
    parameter int unsigned MIN_ON = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_req,
    input  logic pd_req,
    output logic run_o
);
    localparam int unsigned CW = $clog2(MIN_ON + 1);
    localparam logic [CW-1:0] CNT_SAT  = CW'(MIN_ON);
    localparam logic [CW-1:0] CNT_LAST = CW'(MIN_ON - 1);

    typedef struct packed {
        logic          run;
        logic [CW-1:0] cnt;
    } ctrl_st_t;

    ctrl_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!st_q.run) begin
            st_d.cnt = '0;
            if (run_req && !pd_req) begin
                st_d.run = 1'b1;
            end
        end else begin
            if (st_q.cnt != CNT_SAT) begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
            if (pd_req) begin
                st_d.run = 1'b0;
            end else if (!run_req && (st_q.cnt >= CNT_LAST)) begin
                st_d.run = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign run_o = st_q.run;
endmodule

// File: rtl/csg_cell.sv
module csg_cell (
    input  logic clk,
    input  logic en,
    output logic gclk
);
    logic en_l;

    // open only while the clock is low, so the enable settles before a rise
    always_latch begin
        if (!clk) en_l = en;
    end

    assign gclk = clk & en_l;
endmodule

// File: rtl/clk_stop_gate.sv
module clk_stop_gate
    import csg_pkg::*;
#(
    parameter clk_group_e  GROUP    = GRP_CPU,
    parameter int unsigned MIN_ON   = min_on_cycles(GROUP),
    parameter int unsigned PRE_SYNC = pre_sync_stages(GROUP)
) (
    input  logic clk_i,
    input  logic rst_n,
    input  logic stop_n,
    input  logic pwrdn_n,
    output logic gclk_o,
    output logic fclk_o
);
    localparam int unsigned REQ_W = 2;

    logic [REQ_W-1:0] req_raw, req_sync;
    logic             run;

    assign req_raw = {pwrdn_n, stop_n};

    csg_sync #(
        .STAGES (PRE_SYNC),
        .WIDTH  (REQ_W)
    ) u_sync (
        .clk   (clk_i),
        .rst_n (rst_n),
        .d     (req_raw),
        .q     (req_sync)
    );

    csg_ctrl #(
        .MIN_ON (MIN_ON)
    ) u_ctrl (
        .clk     (clk_i),
        .rst_n   (rst_n),
        .run_req (req_sync[0]),
        .pd_req  (!req_sync[1]),
        .run_o   (run)
    );

    csg_cell u_cell (
        .clk  (clk_i),
        .en   (run),
        .gclk (gclk_o)
    );

    assign fclk_o = clk_i;
endmodule

// File: rtl/clk_stop_gate_chk.sv
module clk_stop_gate_chk #(
    parameter int unsigned MIN_ON = 100
) (
    input logic clk,
    input logic rst_n,
    input logic stop_n,
    input logic pwrdn_n,
    input logic gclk
);
    localparam int unsigned LW = $clog2(MIN_ON + 1);

    logic [1:0]    cyc_q;
    logic [LW-1:0] len_q;
    logic          prev_q;
    logic          pd_hit_q;

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cyc_q    <= '0;
            len_q    <= '0;
            prev_q   <= 1'b0;
            pd_hit_q <= 1'b0;
        end else begin
            if (cyc_q != 2'd3) cyc_q <= cyc_q + 1'b1;
            if (!gclk)                  len_q <= '0;
            else if (len_q != LW'(MIN_ON)) len_q <= len_q + 1'b1;
            prev_q <= gclk;
            if (!pwrdn_n)                       pd_hit_q <= 1'b1;
            else if (gclk && !prev_q)           pd_hit_q <= 1'b0;
        end
    end

    // R3: gated clock is low throughout every low phase of the input clock
    p_parked_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !gclk);

    // R7: power-down held for three samples silences the gated clock
    p_pd_off_r7: assert property (@(negedge clk) disable iff (!rst_n)
        (cyc_q >= 2'd2 && !pwrdn_n && $past(!pwrdn_n) && $past(!pwrdn_n, 2))
        |=> !gclk);

    // R5: run request held for three samples yields a pulse
    p_on_latency_r5: assert property (@(negedge clk) disable iff (!rst_n)
        (cyc_q >= 2'd2 && stop_n && pwrdn_n &&
         $past(stop_n && pwrdn_n) && $past(stop_n && pwrdn_n, 2))
        |=> gclk);

    // R6: a pulse train not cut by power-down lasts at least MIN_ON pulses
    p_min_on_r6: assert property (@(negedge clk) disable iff (!rst_n)
        (cyc_q >= 2'd1 && prev_q && !gclk && !pd_hit_q)
        |-> (len_q >= LW'(MIN_ON)));
endmodule

bind clk_stop_gate clk_stop_gate_chk #(.MIN_ON(MIN_ON)) u_chk (
    .clk     (clk_i),
    .rst_n   (rst_n),
    .stop_n  (stop_n),
    .pwrdn_n (pwrdn_n),
    .gclk    (gclk_o)
);

// File: tb/clk_stop_gate_test.sv
`timescale 1ns/1ps
module clk_stop_gate_test;
    import csg_pkg::*;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst_n, stop_c, pd_c, stop_p, pd_p;
    logic gc, fc, gp, fp;
    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;

    clk_stop_gate #(.GROUP(GRP_CPU)) uut (
        .clk_i(clk), .rst_n(rst_n), .stop_n(stop_c), .pwrdn_n(pd_c),
        .gclk_o(gc), .fclk_o(fc));

    clk_stop_gate #(.GROUP(GRP_BUS)) uut_pci (
        .clk_i(clk), .rst_n(rst_n), .stop_n(stop_p), .pwrdn_n(pd_p),
        .gclk_o(gp), .fclk_o(fp));

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic at_low();
        @(negedge clk); #1;
    endtask

    task automatic at_edge(output logic pc, output logic pp);
        @(posedge clk); #1;
        pc = gc;
        pp = gp;
    endtask

    task automatic expect_start(input string tag);
        logic a, b;
        for (int k = 1; k <= 3; k++) begin
            at_edge(a, b);
            chk(a == (k == 3), $sformatf("%s cpu edge %0d", tag, k), int'(a), int'(k == 3));
            if (k <= 2)
                chk(b == (k == 2), $sformatf("%s bus edge %0d", tag, k), int'(b), int'(k == 2));
        end
    endtask

    task automatic expect_stop(input string tag);
        logic a, b;
        for (int k = 1; k <= 6; k++) begin
            at_edge(a, b);
            chk(a == (k <= 2), $sformatf("%s cpu edge %0d", tag, k), int'(a), int'(k <= 2));
            chk(b == (k <= 1), $sformatf("%s bus edge %0d", tag, k), int'(b), int'(k <= 1));
        end
    endtask

    task automatic idle(input int n);
        logic a, b;
        for (int k = 0; k < n; k++) at_edge(a, b);
    endtask

    task automatic t_reset_r1();
        logic a, b;
        rst_n = 1'b0; stop_c = 1'b1; pd_c = 1'b1; stop_p = 1'b1; pd_p = 1'b1;
        for (int k = 0; k < 3; k++) begin
            at_edge(a, b);
            chk(a == 1'b0, "R1 cpu gated low in reset", int'(a), 0);
            chk(b == 1'b0, "R1 bus gated low in reset", int'(b), 0);
            chk(fc == 1'b1, "R2 free clock high in reset", int'(fc), 1);
        end
        at_low();
        rst_n = 1'b1;
        expect_start("R5 reset release");
        idle(120);
    endtask

    task automatic t_free_shape_r2_r3();
        for (int k = 0; k < 8; k++) begin
            @(posedge clk); #0.3;
            chk(gc == 1'b1, "R3 cpu high from start of phase", int'(gc), 1);
            chk(gp == 1'b1, "R3 bus high from start of phase", int'(gp), 1);
            #1.9;
            chk(gc == 1'b1, "R3 cpu high to end of phase", int'(gc), 1);
            @(negedge clk); #0.3;
            chk(gc == 1'b0 && gp == 1'b0, "R3 gated low in low phase", int'(gc | gp), 0);
            chk(fc == 1'b0 && fp == 1'b0, "R2 free clock low", int'(fc | fp), 0);
        end
    endtask

    task automatic t_stop_r4();
        at_low();
        stop_c = 1'b0; stop_p = 1'b0;
        expect_stop("R4 stop");
        for (int k = 0; k < 4; k++) begin
            @(posedge clk); #1;
            chk(fc == 1'b1 && fp == 1'b1, "R2 free clock runs while stopped", int'(fc & fp), 1);
            @(negedge clk); #1;
            chk(gc == 1'b0, "R3 parked low", int'(gc), 0);
        end
    endtask

    task automatic t_start_r5();
        at_low();
        stop_c = 1'b1; stop_p = 1'b1;
        expect_start("R5 restart");
        idle(120);
        at_low();
        stop_c = 1'b0; stop_p = 1'b0;
        idle(10);
    endtask

    task automatic t_min_on_r6();
        logic a, b;
        int   na, nb;
        na = 0; nb = 0;
        at_low();
        stop_c = 1'b1; stop_p = 1'b1;
        at_low();
        stop_c = 1'b0; stop_p = 1'b0;
        for (int k = 0; k < 130; k++) begin
            at_edge(a, b);
            na += int'(a);
            nb += int'(b);
        end
        chk(na == 100, "R6 R8 cpu pulses after brief run request", na, 100);
        chk(nb == 10, "R6 R8 bus pulses after brief run request", nb, 10);
        chk(a == 1'b0 && b == 1'b0, "R6 parked after hold", int'(a | b), 0);
    endtask

    task automatic t_pwrdn_r7();
        logic a, b;
        int   n;
        at_low();
        stop_c = 1'b1; stop_p = 1'b1;
        idle(6);
        at_low();
        pd_c = 1'b0; pd_p = 1'b0;
        expect_stop("R7 power-down before min on-time");
        n = 0;
        for (int k = 0; k < 12; k++) begin
            at_low();
            stop_c = k[0]; stop_p = ~k[0];
            at_edge(a, b);
            n += int'(a) + int'(b);
        end
        chk(n == 0, "R7 stop input ignored in power-down", n, 0);
        at_low();
        stop_c = 1'b1; stop_p = 1'b1;
        idle(3);
        chk(gc == 1'b0 && gp == 1'b0, "R7 still parked", int'(gc | gp), 0);
        at_low();
        pd_c = 1'b1; pd_p = 1'b1;
        expect_start("R7 power-up");
    endtask

    initial begin
        t_reset_r1();
        t_free_shape_r2_r3();
        t_stop_r4();
        t_start_r5();
        t_min_on_r6();
        t_pwrdn_r7();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #500000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule